// File: doc/BRIEF.md
# Quasi-Bidirectional Port

This block is an 8-bit general-purpose port of the kind classic small microcontrollers have. Each bit holds an output latch written from the internal data bus. The latch controls an open-drain pull-down on the pad: a latched 0 turns the pull-down on, and a latched 1 turns it off. With the pull-down off, the pad is held high by an optional weak internal pull-up, or by whatever the outside world applies. A bit therefore works as an input only after software has written a 1 to it. Writing all ones makes the whole port an input.

The CPU reads the port in one of two ways. A read-latch strobe returns the stored latch values in the same cycle. A read-pin strobe returns the pad levels, which reach the read path through a two-flop synchronizer, with each bit masked by its own latch. A bit that holds 0 therefore always reads low on a pin read. There are no real tri-states here. The pad side is a pull-down enable, a pull-up-present flag and a sampled pad level. The bus side is a data vector with an enable.

A per-bit sticky overstress flag records a bit whose pull-down was on while a test input reported an external source forcing that pin high. A dedicated strobe clears the flags.

Top module: `qb_port`

## Requirements
- R1: After a synchronous reset every latch bit is 1, so `pad_pull_dn` is 0x00. Every `overstress` bit is 0, and the synchronizer holds all ones.
- R2: When `wr_en` is high at a clock edge, the latch takes `wr_data`. From then on, `pad_pull_dn` equals the bitwise inverse of the latch. Writing 0x55 gives `pad_pull_dn` = 0xAA, and writing 0xAA gives 0x55.
- R3: While `rd_latch` is high and `rd_pin` is low, `bus_oe` is 1 and `bus_out` equals the current latch contents in the same cycle.
- R4: While `rd_pin` is high, `bus_out` is `pad_in` delayed by two clock edges, ANDed bit by bit with the latch. A change on `pad_in` becomes visible after exactly the second clock edge.
- R5: A bit whose latch holds 0 reads 0 on a pin read, whatever level `pad_in` has for that bit.
- R6: With neither read strobe high, `bus_oe` is 0 and `bus_out` is 0x00.
- R7: With both read strobes high, the pin read wins: `bus_out` carries the masked pad value.
- R8: A read in the same cycle as a write returns the value from before the write. The write is visible from the next cycle onward.
- R9: With parameter `HAS_PULLUP` = 1 (the default), `pad_pull_up` equals the latch. With `HAS_PULLUP` = 0, `pad_pull_up` is 0 on every bit.
- R10: An `overstress` bit is set one edge after a cycle in which its latch bit is 0 and its `ext_force_high` bit is 1. It stays set until a `stress_clr` edge. When setting and clearing fall on the same edge, setting wins.
- R11: A change on `wr_data` with `wr_en` low leaves the latch, and so both read paths, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Latch write strobe |
| wr_data | input | 8 | Data written to the latch |
| rd_latch | input | 1 | Read-latch strobe |
| rd_pin | input | 1 | Read-pin strobe |
| pad_in | input | 8 | Sampled pad levels (asynchronous) |
| ext_force_high | input | 8 | Test input: external source forcing each pin high |
| stress_clr | input | 1 | Clears all overstress flags |
| bus_out | output | 8 | Read data onto the internal bus |
| bus_oe | output | 1 | Read data valid (bus drive enable) |
| pad_pull_dn | output | 8 | Pull-down enable per pin |
| pad_pull_up | output | 8 | Weak pull-up present per pin |
| overstress | output | 8 | Sticky per-bit overstress flags |

## Verification
The main function is driven with pairs of latch value and pad level:

- 0x55 and 0xAA with the pads high exercise the output patterns on the pull-down drive.
- An all-ones latch with varying pad patterns shows that a pin read follows the pads and not the latch.
- An all-zero latch against high pads shows the pin read forced low. Mixed latch and pad values separate a missing mask from a swapped read path.

Directed cases then cover the following:

- the two-edge synchronizer latency;
- both strobes at once, and a read with a write in the same cycle;
- a data change while no write strobe is applied;
- the overstress flag: its set condition, its hold, its clear, and setting winning over clearing.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_LATCH = 2'd1,
    SRC_PIN   = 2'd2
  } rd_src_e;

  function automatic rd_src_e pick_src(input logic pin_req, input logic latch_req);
    if (pin_req)        return SRC_PIN;
    else if (latch_req) return SRC_LATCH;
    else                return SRC_NONE;
  endfunction
endpackage

// File: rtl/qbp_latch_bank.sv
module qbp_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] latch_q
);
  localparam logic [WIDTH-1:0] RESET_VAL = {WIDTH{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)        latch_q <= RESET_VAL;
    else if (wr_en) latch_q <= wr_data;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (latch_q == $past(wr_data))); // R2
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_en)) |-> $stable(latch_q)); // R11
endmodule

// File: rtl/qbp_sync2.sv
module qbp_sync2 #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] IDLE_VAL = {WIDTH{1'b1}};
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= IDLE_VAL;
      q    <= IDLE_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2)) |-> (q == $past(d, 2))); // R4
endmodule

// File: rtl/qbp_read_mux.sv
module qbp_read_mux
  import qbp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_pin,
  input  logic             rd_latch,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] pin_sync,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe
);
  rd_src_e          src;
  logic [WIDTH-1:0] pin_view;

  // A latched 0 keeps the pull-down on, so that pin can only read low.
  assign pin_view = pin_sync & latch_q;

  always_comb begin
    src = pick_src(rd_pin, rd_latch);
    unique case (src)
      SRC_PIN:   begin bus_out = pin_view;       bus_oe = 1'b1; end
      SRC_LATCH: begin bus_out = latch_q;        bus_oe = 1'b1; end
      default:   begin bus_out = '0;             bus_oe = 1'b0; end
    endcase
  end

  AST_PIN_MASKED: assert property (@(posedge clk) disable iff (rst)
    rd_pin |-> ((bus_out & ~latch_q) == '0)); // R5
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!rd_pin && !rd_latch) |-> (!bus_oe && bus_out == '0)); // R6
  AST_OE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_pin || rd_latch) |-> bus_oe); // R3
endmodule

// File: rtl/qbp_stress_mon.sv
module qbp_stress_mon #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] force_hi,
  input  logic             clr,
  output logic [WIDTH-1:0] flag
);
  logic [WIDTH-1:0] hit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign hit[i] = ~latch_q[i] & force_hi[i];
    always_ff @(posedge clk) begin
      if (rst)      flag[i] <= 1'b0;
      else if (clr) flag[i] <= hit[i];
      else          flag[i] <= flag[i] | hit[i];
    end
  end

  AST_STRESS_SET: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (($past(hit) & ~flag) == '0)); // R10
  AST_STRESS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr)) |-> (($past(flag) & ~flag) == '0)); // R10
endmodule

// File: rtl/qb_port.sv
module qb_port #(
  parameter int WIDTH      = 8,
  parameter bit HAS_PULLUP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_latch,
  input  logic             rd_pin,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] ext_force_high,
  input  logic             stress_clr,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic [WIDTH-1:0] pad_pull_dn,
  output logic [WIDTH-1:0] pad_pull_up,
  output logic [WIDTH-1:0] overstress
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] pin_sync;

  qbp_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .latch_q(latch_q)
  );

  qbp_sync2 #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  qbp_read_mux #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst(rst), .rd_pin(rd_pin), .rd_latch(rd_latch),
    .latch_q(latch_q), .pin_sync(pin_sync), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  qbp_stress_mon #(.WIDTH(WIDTH)) u_stress (
    .clk(clk), .rst(rst), .latch_q(latch_q), .force_hi(ext_force_high),
    .clr(stress_clr), .flag(overstress)
  );

  // The inverted latch drives the pull-down gate.
  assign pad_pull_dn = ~latch_q;

  if (HAS_PULLUP) begin : g_pullup
    assign pad_pull_up = latch_q;
  end else begin : g_open_drain
    assign pad_pull_up = '0;
  end

  AST_NO_FIGHT: assert property (@(posedge clk) disable iff (rst)
    ((pad_pull_dn & pad_pull_up) == '0)); // R9
  AST_RESET_RELEASE: assert property (@(posedge clk)
    $past(rst) |-> (pad_pull_dn == '0 && overstress == '0)); // R1
endmodule

// File: tb/qb_port_test.sv
`timescale 1ns/1ps
module qb_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_latch = 1'b0;
  logic         rd_pin = 1'b0;
  logic [W-1:0] pad_in = '1;
  logic [W-1:0] ext_force_high = '0;
  logic         stress_clr = 1'b0;
  logic [W-1:0] bus_out;
  logic         bus_oe;
  logic [W-1:0] pad_pull_dn;
  logic [W-1:0] pad_pull_up;
  logic [W-1:0] overstress;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  qb_port uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_latch(rd_latch), .rd_pin(rd_pin), .pad_in(pad_in),
    .ext_force_high(ext_force_high), .stress_clr(stress_clr),
    .bus_out(bus_out), .bus_oe(bus_oe), .pad_pull_dn(pad_pull_dn),
    .pad_pull_up(pad_pull_up), .overstress(overstress)
  );

  // Each entry: latch data, pad level, expected pin read, expected pull-down.
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    32'h55_FF_55_AA, 32'hAA_FF_AA_55, 32'hFF_3C_3C_00, 32'hFF_C3_C3_00,
    32'h00_FF_00_FF, 32'h0F_A5_05_F0, 32'hF0_FF_F0_0F
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic write(input logic [W-1:0] d);
    wr_data = d; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic rd_l(output logic [W-1:0] v);
    rd_latch = 1'b1; #1; v = bus_out; rd_latch = 1'b0;
  endtask

  task automatic rd_p(output logic [W-1:0] v);
    rd_pin = 1'b1; #1; v = bus_out; rd_pin = 1'b0;
  endtask

  initial begin
    logic [W-1:0] v;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 pull_dn", pad_pull_dn, 8'h00);
    check("R1 overstress", overstress, 8'h00);
    rd_l(v); check("R1 latch", v, 8'hFF);
    rd_p(v); check("R1 sync", v, 8'hFF);
    // R6 idle bus
    #1; check("R6 bus_out", bus_out, 8'h00);
    check("R6 bus_oe", {7'b0, bus_oe}, 8'h00);
    // R9 pull-up follows latch
    check("R9 pull_up", pad_pull_up, 8'hFF);

    // Vector table: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      pad_in = VEC[i][23:16];
      write(VEC[i][31:24]);
      tick(2);
      check("R2 pull_dn", pad_pull_dn, VEC[i][7:0]);
      rd_l(v); check("R3 latch read", v, VEC[i][31:24]);
      rd_p(v); check("R4 R5 pin read", v, VEC[i][15:8]);
      check("R9 pull_up", pad_pull_up, VEC[i][31:24]);
    end

    // R4 latency: two edges
    write(8'hFF);
    pad_in = 8'h00; tick(3);
    pad_in = 8'h96;
    tick(1);
    rd_p(v); check("R4 after one edge", v, 8'h00);
    tick(1);
    rd_p(v); check("R4 after two edges", v, 8'h96);

    // R7 both strobes: pin wins
    write(8'h0F);
    rd_pin = 1'b1; rd_latch = 1'b1; #1;
    check("R7 both strobes", bus_out, 8'h06);
    rd_pin = 1'b0; rd_latch = 1'b0;

    // R8 read during write returns old value
    tick(1);
    wr_data = 8'h3C; wr_en = 1'b1; rd_latch = 1'b1; #1;
    check("R8 same-cycle read", bus_out, 8'h0F);
    tick(1);
    wr_en = 1'b0; #1;
    check("R8 next cycle", bus_out, 8'h3C);
    rd_latch = 1'b0;

    // R11 data change without strobe
    wr_data = 8'hC1; tick(2);
    rd_l(v); check("R11 latch unchanged", v, 8'h3C);
    pad_in = 8'hFF; tick(2);
    rd_p(v); check("R11 pin unchanged", v, 8'h3C);

    // R10 overstress
    write(8'h0F);
    ext_force_high = 8'h0F; tick(1);
    check("R10 no stress on latch-1 bits", overstress, 8'h00);
    ext_force_high = 8'hF0; tick(1);
    check("R10 set", overstress, 8'hF0);
    ext_force_high = 8'h00; tick(2);
    check("R10 sticky", overstress, 8'hF0);
    stress_clr = 1'b1; tick(1); stress_clr = 1'b0;
    check("R10 clear", overstress, 8'h00);
    stress_clr = 1'b1; ext_force_high = 8'h10; tick(1);
    stress_clr = 1'b0; ext_force_high = 8'h00;
    check("R10 set wins", overstress, 8'h10);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule